// File: doc/BRIEF.md
# Wakeup-and-Select Issue Queue

This block holds renamed operations between dispatch and execution in an out-of-order core. Up to two operations arrive per cycle and each lands in the lowest-numbered empty slot. A slot keeps the opcode, the destination tag and one ready bit per source in plain registers. The two source tags of each slot are compared every cycle against every result tag broadcast on the wakeup ports. A match sets that source's ready bit. A source is also written as ready at dispatch if the dispatcher marks it available, or if a wakeup port broadcasts its tag in that same cycle.

Each cycle the selector looks at the waiting slots whose sources are all ready. Working through the free execution slots from the lowest-numbered one upward, it gives each free slot the oldest such slot, by dispatch order, that is not yet taken. A slot that has issued is not freed. It is held in an issued state until a validate command names it, which frees it. A replay command instead returns it to waiting with every ready bit cleared, so it must be woken again before it reissues. A flush empties the whole queue in one cycle. The dispatcher sees the number of empty slots and a full flag.

Top module: `issue_queue`

## Requirements
- R1: While reset is held and on the first cycle after it, `free_count` is 16, `full` is 0 and no `iss_valid` bit is set.
- R2: In a cycle, the dispatch requests are taken in port order, one per empty slot, each into the lowest-numbered empty slot left. Requests beyond the number of empty slots are dropped: with one slot empty and both ports valid, port 0 is accepted and port 1 is dropped. `free_count` falls by the number accepted on the next cycle, and `full` is 1 exactly when it is 0.
- R3: A waiting slot is offered for issue only when all its ready bits are set. A source that is not ready becomes ready on the cycle after a wakeup port broadcasts a tag equal to it. An issue slot reports the opcode, destination tag and slot index of the operation it carries.
- R4: A source dispatched with its ready flag set, or whose tag a wakeup port broadcasts in the dispatch cycle, is stored ready. The operation can issue on the next cycle.
- R5: Among ready slots, older dispatches are chosen first, whatever their slot index. Within one cycle, port 0 counts as older than port 1.
- R6: Only issue slots whose `fu_free` bit is set report an operation. The oldest ready operation goes to the lowest-numbered free issue slot, the next oldest to the next free issue slot. No slot index appears twice in one cycle.
- R7: An issued slot stays occupied (`free_count` unchanged) and is not offered again until it is validated or replayed.
- R8: A validate naming an issued slot frees it from the next cycle. A validate naming a slot that has not issued has no effect.
- R9: A replay naming an issued slot returns it to waiting with all its ready bits cleared. It reissues only after fresh matching wakeups. A wakeup broadcast in the replay cycle still counts.
- R10: A flush frees every slot on the next cycle, drops any dispatch in the same cycle, and no `iss_valid` bit is set in the flush cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the whole queue |
| disp_valid | input | 2 | Dispatch request per port |
| disp_op | input | 2x8 | Opcode per dispatch port |
| disp_dst | input | 2x6 | Destination tag per dispatch port |
| disp_src | input | 2x2x6 | Two source tags per dispatch port |
| disp_rdy | input | 2x2 | Source already available, per port and source |
| wake_valid | input | 2 | Wakeup broadcast valid per port |
| wake_tag | input | 2x6 | Broadcast result tag per port |
| fu_free | input | 2 | Execution slot available this cycle, per issue slot |
| val_valid | input | 1 | Validate command |
| val_idx | input | 4 | Slot index to validate |
| rep_valid | input | 1 | Replay command |
| rep_idx | input | 4 | Slot index to replay |
| iss_valid | output | 2 | Operation issued on this slot |
| iss_op | output | 2x8 | Issued opcode per slot |
| iss_dst | output | 2x6 | Issued destination tag per slot |
| iss_idx | output | 2x4 | Queue slot index of the issued operation |
| free_count | output | 5 | Number of empty queue slots |
| full | output | 1 | No empty slot left |

## Verification
The hardest case to reach is one where age and slot index disagree. After a flush, slots fill from index 0 upward in dispatch order, so the oldest slot is always the lowest index. The bench therefore issues and validates slot 0 while an older operation in slot 1 still waits on a tag, and then refills slot 0 with a younger ready operation. Once the older operation is woken, the bench changes `fu_free` within one cycle to show that age alone decides which slot gets it. Replay is reached the same way: an operation is issued, then replayed, and the bench then shows that a source that had been ready since dispatch must be woken again.

// File: rtl/iq_pkg.sv
package iq_pkg;

    localparam int IQ_ENTRIES = 16;
    localparam int IQ_NSRC    = 2;
    localparam int IQ_TAG_W   = 6;
    localparam int IQ_DISP    = 2;
    localparam int IQ_WAKE    = 2;
    localparam int IQ_ISSUE   = 2;
    localparam int IQ_OP_W    = 8;

    typedef enum logic [1:0] {
        ST_FREE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_ISSUED = 2'd2
    } ent_state_e;

    function automatic int width_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/iq_entry.sv
module iq_entry
    import iq_pkg::*;
#(
    parameter int OP_W  = IQ_OP_W,
    parameter int TAG_W = IQ_TAG_W,
    parameter int NSRC  = IQ_NSRC,
    parameter int WAKE  = IQ_WAKE
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       wr_en,
    input  logic [OP_W-1:0]            wr_op,
    input  logic [TAG_W-1:0]           wr_dst,
    input  logic [NSRC-1:0][TAG_W-1:0] wr_src,
    input  logic [NSRC-1:0]            wr_rdy,
    input  logic [WAKE-1:0]            wake_valid,
    input  logic [WAKE-1:0][TAG_W-1:0] wake_tag,
    input  logic                       grant,
    input  logic                       validate,
    input  logic                       replay,
    output ent_state_e                 state,
    output logic [OP_W-1:0]            op,
    output logic [TAG_W-1:0]           dst,
    output logic                       ready
);

    logic [NSRC-1:0][TAG_W-1:0] src_q;
    logic [NSRC-1:0]            rdy_q;
    logic [NSRC-1:0]            hit;

    // associative compare of every stored source tag against every broadcast
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            hit[s] = 1'b0;
            for (int w = 0; w < WAKE; w++) begin
                if (wake_valid[w] && (wake_tag[w] == src_q[s])) hit[s] = 1'b1;
            end
        end
    end

    assign ready = (state == ST_WAIT) && (&rdy_q);

    always_ff @(posedge clk) begin
        if (wr_en) begin
            op    <= wr_op;
            dst   <= wr_dst;
            src_q <= wr_src;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state <= ST_FREE;
            rdy_q <= '0;
        end else if (wr_en) begin
            state <= ST_WAIT;
            rdy_q <= wr_rdy;
        end else begin
            case (state)
                ST_WAIT: begin
                    rdy_q <= rdy_q | hit;
                    if (grant) state <= ST_ISSUED;
                end
                ST_ISSUED: begin
                    if (validate) begin
                        state <= ST_FREE;
                    end else if (replay) begin
                        state <= ST_WAIT;
                        rdy_q <= hit;
                    end else begin
                        rdy_q <= rdy_q | hit;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/iq_alloc.sv
module iq_alloc
    import iq_pkg::*;
#(
    parameter int ENTRIES = IQ_ENTRIES,
    parameter int DISP    = IQ_DISP,
    parameter int PORT_W  = width_of(IQ_DISP)
) (
    input  logic [ENTRIES-1:0]             free_vec,
    input  logic [DISP-1:0]                disp_valid,
    output logic [ENTRIES-1:0]             wr_en,
    output logic [ENTRIES-1:0][PORT_W-1:0] wr_port
);

    logic [ENTRIES-1:0] avail;
    logic               found;

    // port p takes the lowest empty slot not claimed by a lower port
    always_comb begin
        avail   = free_vec;
        wr_en   = '0;
        wr_port = '0;
        found   = 1'b0;
        for (int p = 0; p < DISP; p++) begin
            found = 1'b0;
            if (disp_valid[p]) begin
                for (int e = 0; e < ENTRIES; e++) begin
                    if (!found && avail[e]) begin
                        found      = 1'b1;
                        avail[e]   = 1'b0;
                        wr_en[e]   = 1'b1;
                        wr_port[e] = PORT_W'(p);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/iq_select.sv
module iq_select
    import iq_pkg::*;
#(
    parameter int ENTRIES = IQ_ENTRIES,
    parameter int ISSUE   = IQ_ISSUE,
    parameter int IDX_W   = width_of(IQ_ENTRIES),
    parameter int PORT_W  = width_of(IQ_DISP)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [ENTRIES-1:0]             wr_en,
    input  logic [ENTRIES-1:0][PORT_W-1:0] wr_port,
    input  logic [ENTRIES-1:0]             cand,
    input  logic [ISSUE-1:0]               slot_free,
    output logic [ISSUE-1:0]               iss_valid,
    output logic [ISSUE-1:0][IDX_W-1:0]    iss_idx,
    output logic [ENTRIES-1:0]             grant_vec
);

    // older_q[i][j] set: slot i was dispatched before slot j
    logic [ENTRIES-1:0][ENTRIES-1:0] older_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            older_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                for (int j = 0; j < ENTRIES; j++) begin
                    if (wr_en[i] && wr_en[j])
                        older_q[i][j] <= (wr_port[i] < wr_port[j]);
                    else if (wr_en[i])
                        older_q[i][j] <= 1'b0;
                    else if (wr_en[j])
                        older_q[i][j] <= 1'b1;
                end
            end
        end
    end

    logic [ENTRIES-1:0] remain;
    logic               taken;
    logic               blocked;

    always_comb begin
        remain    = cand;
        grant_vec = '0;
        iss_valid = '0;
        iss_idx   = '0;
        taken     = 1'b0;
        blocked   = 1'b0;
        for (int s = 0; s < ISSUE; s++) begin
            taken = 1'b0;
            if (slot_free[s]) begin
                for (int c = 0; c < ENTRIES; c++) begin
                    blocked = 1'b0;
                    for (int d = 0; d < ENTRIES; d++) begin
                        if (remain[d] && older_q[d][c]) blocked = 1'b1;
                    end
                    if (!taken && remain[c] && !blocked) begin
                        taken        = 1'b1;
                        remain[c]    = 1'b0;
                        grant_vec[c] = 1'b1;
                        iss_valid[s] = 1'b1;
                        iss_idx[s]   = IDX_W'(c);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/issue_queue.sv
module issue_queue
    import iq_pkg::*;
#(
    parameter int ENTRIES = IQ_ENTRIES,
    parameter int NSRC    = IQ_NSRC,
    parameter int TAG_W   = IQ_TAG_W,
    parameter int DISP    = IQ_DISP,
    parameter int WAKE    = IQ_WAKE,
    parameter int ISSUE   = IQ_ISSUE,
    parameter int OP_W    = IQ_OP_W,
    localparam int IDX_W  = width_of(ENTRIES),
    localparam int PORT_W = width_of(DISP),
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 flush,
    input  logic [DISP-1:0]                      disp_valid,
    input  logic [DISP-1:0][OP_W-1:0]            disp_op,
    input  logic [DISP-1:0][TAG_W-1:0]           disp_dst,
    input  logic [DISP-1:0][NSRC-1:0][TAG_W-1:0] disp_src,
    input  logic [DISP-1:0][NSRC-1:0]            disp_rdy,
    input  logic [WAKE-1:0]                      wake_valid,
    input  logic [WAKE-1:0][TAG_W-1:0]           wake_tag,
    input  logic [ISSUE-1:0]                     fu_free,
    input  logic                                 val_valid,
    input  logic [IDX_W-1:0]                     val_idx,
    input  logic                                 rep_valid,
    input  logic [IDX_W-1:0]                     rep_idx,
    output logic [ISSUE-1:0]                     iss_valid,
    output logic [ISSUE-1:0][OP_W-1:0]           iss_op,
    output logic [ISSUE-1:0][TAG_W-1:0]          iss_dst,
    output logic [ISSUE-1:0][IDX_W-1:0]          iss_idx,
    output logic [CNT_W-1:0]                     free_count,
    output logic                                 full
);

    ent_state_e                 ent_state [ENTRIES];
    logic [OP_W-1:0]            ent_op    [ENTRIES];
    logic [TAG_W-1:0]           ent_dst   [ENTRIES];
    logic [ENTRIES-1:0]         ent_ready;
    logic [ENTRIES-1:0]         free_vec;
    logic [ENTRIES-1:0]         wr_en;
    logic [ENTRIES-1:0][PORT_W-1:0] wr_port;
    logic [ENTRIES-1:0]         grant_vec;
    logic [ENTRIES-1:0]         cand;
    logic [DISP-1:0][NSRC-1:0]  byp_rdy;

    always_comb begin
        for (int e = 0; e < ENTRIES; e++) free_vec[e] = (ent_state[e] == ST_FREE);
    end

    assign free_count = CNT_W'($countones(free_vec));
    assign full       = (free_vec == '0);

    // same-cycle bypass of broadcast tags into the dispatched ready bits
    always_comb begin
        for (int p = 0; p < DISP; p++) begin
            for (int s = 0; s < NSRC; s++) begin
                byp_rdy[p][s] = disp_rdy[p][s];
                for (int w = 0; w < WAKE; w++) begin
                    if (wake_valid[w] && (wake_tag[w] == disp_src[p][s])) byp_rdy[p][s] = 1'b1;
                end
            end
        end
    end

    iq_alloc #(.ENTRIES(ENTRIES), .DISP(DISP), .PORT_W(PORT_W)) u_alloc (
        .free_vec   (free_vec),
        .disp_valid (disp_valid),
        .wr_en      (wr_en),
        .wr_port    (wr_port)
    );

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic [PORT_W-1:0] pe;
        assign pe = wr_port[e];
        iq_entry #(.OP_W(OP_W), .TAG_W(TAG_W), .NSRC(NSRC), .WAKE(WAKE)) u_ent (
            .clk        (clk),
            .rst        (rst),
            .flush      (flush),
            .wr_en      (wr_en[e]),
            .wr_op      (disp_op[pe]),
            .wr_dst     (disp_dst[pe]),
            .wr_src     (disp_src[pe]),
            .wr_rdy     (byp_rdy[pe]),
            .wake_valid (wake_valid),
            .wake_tag   (wake_tag),
            .grant      (grant_vec[e]),
            .validate   (val_valid && (val_idx == IDX_W'(e))),
            .replay     (rep_valid && (rep_idx == IDX_W'(e))),
            .state      (ent_state[e]),
            .op         (ent_op[e]),
            .dst        (ent_dst[e]),
            .ready      (ent_ready[e])
        );
    end

    assign cand = ent_ready & {ENTRIES{!flush}};

    iq_select #(.ENTRIES(ENTRIES), .ISSUE(ISSUE), .IDX_W(IDX_W), .PORT_W(PORT_W)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_port   (wr_port),
        .cand      (cand),
        .slot_free (fu_free),
        .iss_valid (iss_valid),
        .iss_idx   (iss_idx),
        .grant_vec (grant_vec)
    );

    always_comb begin
        for (int s = 0; s < ISSUE; s++) begin
            iss_op[s]  = ent_op[iss_idx[s]];
            iss_dst[s] = ent_dst[iss_idx[s]];
        end
    end

endmodule

// File: rtl/iq_checker.sv
module iq_checker
    import iq_pkg::*;
#(
    parameter int ENTRIES = IQ_ENTRIES,
    parameter int DISP    = IQ_DISP,
    parameter int ISSUE   = IQ_ISSUE,
    parameter int IDX_W   = width_of(IQ_ENTRIES),
    parameter int CNT_W   = $clog2(IQ_ENTRIES + 1)
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        flush,
    input logic [ISSUE-1:0]            fu_free,
    input logic [ISSUE-1:0]            iss_valid,
    input logic [ISSUE-1:0][IDX_W-1:0] iss_idx,
    input logic [CNT_W-1:0]            free_count,
    input ent_state_e                  ent_state [ENTRIES],
    input logic [ENTRIES-1:0]          ent_ready
);

    for (genvar s = 0; s < ISSUE; s++) begin : g_slot
        assert_slot_free_R6: assert property (@(posedge clk) disable iff (rst)
            iss_valid[s] |-> fu_free[s]);

        assert_pick_ready_R3: assert property (@(posedge clk) disable iff (rst)
            iss_valid[s] |-> ent_ready[iss_idx[s]]);

        assert_held_issued_R7: assert property (@(posedge clk) disable iff (rst)
            (iss_valid[s] && !flush) |=> (ent_state[$past(iss_idx[s])] == ST_ISSUED));

        if (s > 0) begin : g_pair
            assert_distinct_R6: assert property (@(posedge clk) disable iff (rst)
                (iss_valid[0] && iss_valid[s]) |-> (iss_idx[0] != iss_idx[s]));
        end
    end

    assert_flush_empty_R10: assert property (@(posedge clk) disable iff (rst)
        flush |=> (int'(free_count) == ENTRIES));

    assert_alloc_rate_R2: assert property (@(posedge clk) disable iff (rst)
        !flush |=> (int'(free_count) + DISP >= int'($past(free_count))));

endmodule

bind issue_queue iq_checker #(
    .ENTRIES (ENTRIES),
    .DISP    (DISP),
    .ISSUE   (ISSUE),
    .IDX_W   (IDX_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .fu_free    (fu_free),
    .iss_valid  (iss_valid),
    .iss_idx    (iss_idx),
    .free_count (free_count),
    .ent_state  (ent_state),
    .ent_ready  (ent_ready)
);

// File: tb/tb_issue_queue.sv
module tb_issue_queue;

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  flush;
    logic [1:0]            disp_valid;
    logic [1:0][7:0]       disp_op;
    logic [1:0][5:0]       disp_dst;
    logic [1:0][1:0][5:0]  disp_src;
    logic [1:0][1:0]       disp_rdy;
    logic [1:0]            wake_valid;
    logic [1:0][5:0]       wake_tag;
    logic [1:0]            fu_free;
    logic                  val_valid;
    logic [3:0]            val_idx;
    logic                  rep_valid;
    logic [3:0]            rep_idx;
    logic [1:0]            iss_valid;
    logic [1:0][7:0]       iss_op;
    logic [1:0][5:0]       iss_dst;
    logic [1:0][3:0]       iss_idx;
    logic [4:0]            free_count;
    logic                  full;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    issue_queue dut (
        .clk(clk), .rst(rst), .flush(flush),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_dst(disp_dst),
        .disp_src(disp_src), .disp_rdy(disp_rdy),
        .wake_valid(wake_valid), .wake_tag(wake_tag), .fu_free(fu_free),
        .val_valid(val_valid), .val_idx(val_idx),
        .rep_valid(rep_valid), .rep_idx(rep_idx),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst), .iss_idx(iss_idx),
        .free_count(free_count), .full(full)
    );

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        flush = 0; disp_valid = '0; disp_op = '0; disp_dst = '0; disp_src = '0;
        disp_rdy = '0; wake_valid = '0; wake_tag = '0; fu_free = '0;
        val_valid = 0; val_idx = '0; rep_valid = 0; rep_idx = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic put(input int p, input logic [7:0] op, input logic [5:0] dst,
                       input logic [5:0] s0, input logic [5:0] s1,
                       input logic r0, input logic r1);
        disp_valid[p]  = 1'b1;
        disp_op[p]     = op;
        disp_dst[p]    = dst;
        disp_src[p][0] = s0;
        disp_src[p][1] = s1;
        disp_rdy[p][0] = r0;
        disp_rdy[p][1] = r1;
    endtask

    task automatic wake(input int w, input logic [5:0] tag);
        wake_valid[w] = 1'b1;
        wake_tag[w]   = tag;
    endtask

    task automatic sample(input logic [1:0] ff);
        fu_free = ff;
        #1;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        sample(2'b11);
        chk("R1 free_count after reset", free_count, 16);
        chk("R1 full after reset", full, 0);
        chk("R1 no issue after reset", iss_valid, 0);
        fu_free = '0;
    endtask

    task automatic t_ready_issue();
        do_flush();
        put(0, 8'h11, 6'd5, 6'd1, 6'd2, 1, 1);
        tick();
        sample(2'b01);
        chk("R3 ready op issues", iss_valid, 2'b01);
        chk("R3 issued opcode", iss_op[0], 8'h11);
        chk("R3 issued dst", iss_dst[0], 5);
        chk("R3 issued index", iss_idx[0], 0);
        tick();
        sample(2'b11);
        chk("R7 not offered again", iss_valid, 0);
        chk("R7 still occupied", free_count, 15);
        tick();
        val_valid = 1; val_idx = 4'd0;
        tick();
        chk("R8 validate frees", free_count, 16);
    endtask

    task automatic t_wakeup();
        do_flush();
        put(0, 8'h22, 6'd7, 6'd10, 6'd11, 0, 0);
        tick();
        sample(2'b11);
        chk("R3 blocked without wakeup", iss_valid, 0);
        fu_free = '0;
        wake(0, 6'd10);
        tick();
        sample(2'b11);
        chk("R3 blocked with one source", iss_valid, 0);
        fu_free = '0;
        wake(1, 6'd11);
        tick();
        sample(2'b01);
        chk("R3 issues after wakeup", iss_valid, 2'b01);
        chk("R3 woken opcode", iss_op[0], 8'h22);
    endtask

    task automatic t_bypass();
        do_flush();
        put(0, 8'h33, 6'd8, 6'd20, 6'd21, 0, 0);
        wake(0, 6'd20); wake(1, 6'd21);
        tick();
        sample(2'b01);
        chk("R4 same-cycle bypass both", iss_valid, 2'b01);
        chk("R4 bypass opcode", iss_op[0], 8'h33);
        do_flush();
        put(0, 8'h34, 6'd8, 6'd24, 6'd25, 0, 1);
        wake(1, 6'd24);
        tick();
        sample(2'b01);
        chk("R4 flag plus bypass", iss_valid, 2'b01);
    endtask

    task automatic t_age();
        do_flush();
        put(0, 8'hA0, 6'd1, 6'd0, 6'd0, 1, 1);
        put(1, 8'hB0, 6'd2, 6'd30, 6'd31, 0, 1);
        tick();
        sample(2'b01);
        chk("R5 first op slot", iss_idx[0], 0);
        tick();
        val_valid = 1; val_idx = 4'd0;
        tick();
        put(0, 8'hC0, 6'd3, 6'd0, 6'd0, 1, 1);
        tick();
        wake(0, 6'd30);
        tick();
        sample(2'b01);
        chk("R5 older higher index wins", iss_idx[0], 1);
        chk("R5 older opcode", iss_op[0], 8'hB0);
        sample(2'b11);
        chk("R6 both slots valid", iss_valid, 2'b11);
        chk("R6 slot0 oldest", iss_idx[0], 1);
        chk("R6 slot1 next", iss_idx[1], 0);
        sample(2'b10);
        chk("R6 only free slot used", iss_valid, 2'b10);
        chk("R6 oldest to slot1", iss_idx[1], 1);
        fu_free = '0;
    endtask

    task automatic t_capacity();
        do_flush();
        for (int c = 0; c < 7; c++) begin
            put(0, 8'(c * 2), 6'd9, 6'd50, 6'd50, 0, 0);
            put(1, 8'(c * 2 + 1), 6'd9, 6'd50, 6'd50, 0, 0);
            tick();
        end
        chk("R2 two per cycle", free_count, 2);
        put(1, 8'hD1, 6'd9, 6'd50, 6'd50, 0, 0);
        tick();
        chk("R2 port1 alone accepted", free_count, 1);
        put(0, 8'hE0, 6'd9, 6'd0, 6'd0, 1, 1);
        put(1, 8'hE1, 6'd9, 6'd0, 6'd0, 1, 1);
        tick();
        chk("R2 free_count zero", free_count, 0);
        chk("R2 full set", full, 1);
        sample(2'b11);
        chk("R2 only port0 kept", iss_valid, 2'b01);
        chk("R2 kept opcode", iss_op[0], 8'hE0);
        fu_free = '0;
        put(0, 8'hF0, 6'd9, 6'd0, 6'd0, 1, 1);
        tick();
        chk("R2 dropped when full", free_count, 0);
    endtask

    task automatic t_replay();
        do_flush();
        put(0, 8'h70, 6'd4, 6'd40, 6'd41, 0, 1);
        wake(0, 6'd40);
        tick();
        fu_free = 2'b01;
        tick();
        rep_valid = 1; rep_idx = 4'd0;
        tick();
        sample(2'b11);
        chk("R9 no issue after replay", iss_valid, 0);
        chk("R9 stays occupied", free_count, 15);
        fu_free = '0;
        wake(0, 6'd40);
        tick();
        sample(2'b11);
        chk("R9 flags all cleared", iss_valid, 0);
        fu_free = '0;
        wake(0, 6'd41);
        tick();
        sample(2'b01);
        chk("R9 reissue after wakeups", iss_valid, 2'b01);
        chk("R9 reissue index", iss_idx[0], 0);
        tick();
        rep_valid = 1; rep_idx = 4'd0;
        wake(0, 6'd40); wake(1, 6'd41);
        tick();
        sample(2'b01);
        chk("R9 wakeup in replay cycle", iss_valid, 2'b01);
        fu_free = '0;
    endtask

    task automatic t_validate_waiting();
        do_flush();
        put(0, 8'h80, 6'd4, 6'd60, 6'd61, 0, 0);
        tick();
        val_valid = 1; val_idx = 4'd0;
        tick();
        chk("R8 validate on waiting ignored", free_count, 15);
        wake(0, 6'd60); wake(1, 6'd61);
        tick();
        sample(2'b01);
        chk("R8 waiting op still present", iss_op[0], 8'h80);
        fu_free = '0;
    endtask

    task automatic t_flush();
        do_flush();
        put(0, 8'h90, 6'd1, 6'd0, 6'd0, 1, 1);
        put(1, 8'h91, 6'd1, 6'd0, 6'd0, 1, 1);
        tick();
        flush = 1'b1;
        put(0, 8'h92, 6'd1, 6'd0, 6'd0, 1, 1);
        sample(2'b11);
        chk("R10 no issue in flush cycle", iss_valid, 0);
        tick();
        chk("R10 all free after flush", free_count, 16);
        sample(2'b11);
        chk("R10 flush-cycle dispatch dropped", iss_valid, 0);
        fu_free = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        sample(2'b11);
        chk("R1 no issue during reset", iss_valid, 0);
        fu_free = '0;
        rst = 1'b0;
        t_reset();
        t_ready_issue();
        t_wakeup();
        t_bypass();
        t_age();
        t_capacity();
        t_replay();
        t_validate_waiting();
        t_flush();
        report();
        $finish;
    end

endmodule